// File: doc/BRIEF.md
# Pixel Word Unpacker

The block takes 32-bit words of a frame buffer from a valid/ready stream and splits each one into pixels. Each pixel is turned into a 24-bit colour, one per cycle in which the pixel-clock enable is high. A 3-bit depth code picks the pixel size and format.

Depths of 8 bits or fewer are colour indices. Each index is looked up in a 256-entry palette RAM that has its own write port. The 16-bit formats and the 24-bit format are expanded arithmetically into 8-bit channels.

Three static controls modify the result:
- byte order of the input word;
- order of sub-byte pixels inside a byte;
- exchange of the red and blue channels at the output.

The block sits between the frame fetch FIFO and the panel output stage.

Top module: `pix_unpack`

## Requirements
- R1: While rst_ni is low and until the first accepted word, pix_valid_o is 0, pix_o is 0 and word_ready_o is 1.
- R2: A word is taken at a rising edge where word_valid_i and word_ready_o are both high. From that edge, word_ready_o stays low until the rising edge at which the last pixel of the word is emitted. After that edge it is high again.
- R3: The depth code mode_i sets the pixels per word: 0 gives 32, 1 gives 16, 2 gives 8, 3 gives 4, 4, 6 and 7 give 2, and 5 gives 1. One pixel is consumed at each rising edge with pix_en_i high while a word is held. pix_en_i with no word held emits nothing.
- R4: pix_valid_o is high for exactly the one cycle after each edge that consumed a pixel, with pix_o carrying that pixel. In every other cycle pix_o holds its last value.
- R5: With byte_be_i = 0, pixel k is taken from bit position k times the depth, counting from bit 0. With byte_be_i = 1, the four bytes of the word are reversed first, so bits [31:24] move to [7:0], and the same rule is applied.
- R6: For depths below 8, pixels fill a byte before moving to the next. With pix_be_i = 0, the first pixel of a byte is at its lowest bits. With pix_be_i = 1, it is at its highest bits.
- R7: For codes 0 to 3, the pixel value is zero-extended to an 8-bit index and the palette entry is output. A palette entry is laid out as red [23:16], green [15:8], blue [7:0], which is also the layout of pix_o.
- R8: The palette is written through pal_we_i, pal_waddr_i and pal_wdata_i at any edge. A lookup of the same entry at that edge returns the previous contents, and later lookups return the new data.
- R9: Code 4 maps red to bits [4:0], green to [9:5] and blue to [14:10]. Bit 15 has no effect. Each 5-bit channel c becomes {c, c[4:2]}.
- R10: Code 6 maps red to [4:0], green to [10:5] and blue to [15:11]. A 6-bit channel c becomes {c, c[5:4]}, and 5-bit channels expand as in R9.
- R11: Code 7 maps red to [3:0], green to [7:4] and blue to [11:8]. Bits [15:12] are ignored. Each 4-bit channel c becomes {c, c}.
- R12: Code 5 maps red to [7:0], green to [15:8] and blue to [23:16]. Bits [31:24] are ignored.
- R13: When swap_rb_i is high, bits [23:16] and [7:0] of pix_o are exchanged, in every depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Depth and format code |
| byte_be_i | input | 1 | Reverse byte order of input words |
| pix_be_i | input | 1 | First sub-byte pixel at the high end of the byte |
| swap_rb_i | input | 1 | Exchange red and blue at the output |
| word_i | input | 32 | Frame buffer word |
| word_valid_i | input | 1 | word_i is valid |
| word_ready_o | output | 1 | Block can take a word |
| pix_en_i | input | 1 | Pixel clock enable |
| pal_we_i | input | 1 | Palette write enable |
| pal_waddr_i | input | PAL_AW | Palette write address |
| pal_wdata_i | input | 24 | Palette write data |
| pix_o | output | 24 | Output colour |
| pix_valid_o | output | 1 | pix_o carries a new pixel this cycle |

## Verification
A pixel is due in the cycle right after the rising edge that sampled pix_en_i high. There is one register level on the way, and the palette read shares that same edge.

word_ready_o falls in the cycle after the edge that accepted a word. It rises in the cycle after the edge that consumed the last pixel.

The reference model steps once per rising edge and compares all three outputs 1 ns later. Inputs are changed only at that moment, so every edge sees settled stimulus.

The model resolves palette indices at the consuming edge, before applying any write of that same edge.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;
  localparam int WORD_W = 32;
  localparam int RGB_W  = 24;
  localparam int IDX_W  = $clog2(WORD_W);

  typedef enum logic [2:0] {
    DEPTH_1   = 3'd0,
    DEPTH_2   = 3'd1,
    DEPTH_4   = 3'd2,
    DEPTH_8   = 3'd3,
    DEPTH_16I = 3'd4,
    DEPTH_24  = 3'd5,
    DEPTH_565 = 3'd6,
    DEPTH_444 = 3'd7
  } depth_e;

  function automatic logic [5:0] pix_per_word(depth_e d);
    case (d)
      DEPTH_1:  return 6'd32;
      DEPTH_2:  return 6'd16;
      DEPTH_4:  return 6'd8;
      DEPTH_8:  return 6'd4;
      DEPTH_24: return 6'd1;
      default:  return 6'd2;
    endcase
  endfunction

  function automatic logic [RGB_W-1:0] pix_mask(depth_e d);
    case (d)
      DEPTH_1:  return 24'h000001;
      DEPTH_2:  return 24'h000003;
      DEPTH_4:  return 24'h00000f;
      DEPTH_8:  return 24'h0000ff;
      DEPTH_24: return 24'hffffff;
      default:  return 24'h00ffff;
    endcase
  endfunction

  function automatic logic is_indexed(depth_e d);
    return d <= DEPTH_8;
  endfunction
endpackage

// File: rtl/pix_word_slicer.sv
module pix_word_slicer
  import pix_unpack_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  depth_e            depth_i,
  input  logic              byte_be_i,
  input  logic              pix_be_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  input  logic              pix_en_i,
  output logic              fire_o,
  output logic [RGB_W-1:0]  field_o
);
  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] word_q, word_rev, word_eff;
  logic              have_q, last;
  logic [IDX_W-1:0]  idx_q;
  logic [5:0]        idx6, shift, slots_m1, sub, slot, byte_idx;
  logic [1:0]        lg;

  for (genvar b = 0; b < NBYTES; b++) begin : g_rev
    assign word_rev[b*8 +: 8] = word_q[(NBYTES-1-b)*8 +: 8];
  end

  assign word_eff = byte_be_i ? word_rev : word_q;
  assign idx6     = {{(6-IDX_W){1'b0}}, idx_q};
  assign lg       = depth_i[1:0];

  always_comb begin
    slots_m1 = (6'd8 >> lg) - 6'd1;
    sub      = idx6 & slots_m1;
    byte_idx = idx6 >> (6'd3 - {4'd0, lg});
    slot     = pix_be_i ? (slots_m1 - sub) : sub;
    case (depth_i)
      DEPTH_1, DEPTH_2, DEPTH_4: shift = (byte_idx << 3) + (slot << lg);
      DEPTH_8:                   shift = idx6 << 3;
      DEPTH_24:                  shift = 6'd0;
      default:                   shift = idx6 << 4;
    endcase
  end

  assign field_o      = RGB_W'(word_eff >> shift) & pix_mask(depth_i);
  assign last         = (idx6 == pix_per_word(depth_i) - 6'd1);
  assign fire_o       = have_q && pix_en_i;
  assign word_ready_o = !have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      idx_q  <= '0;
      word_q <= '0;
    end else if (word_valid_i && !have_q) begin
      have_q <= 1'b1;
      idx_q  <= '0;
      word_q <= word_i;
    end else if (fire_o) begin
      idx_q <= idx_q + 1'b1;
      if (last) have_q <= 1'b0;
    end
  end

  assert_busy_after_take_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && word_ready_o) |=> !word_ready_o);
  assert_free_after_last_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && last) |=> word_ready_o);
  assert_idx_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    have_q |-> (idx6 < pix_per_word(depth_i)));
endmodule

// File: rtl/pix_color_expand.sv
module pix_color_expand
  import pix_unpack_pkg::*;
(
  input  depth_e            depth_i,
  input  logic [RGB_W-1:0]  field_i,
  output logic [RGB_W-1:0]  rgb_o
);
  function automatic logic [7:0] up5(logic [4:0] c);
    return {c, c[4:2]};
  endfunction
  function automatic logic [7:0] up6(logic [5:0] c);
    return {c, c[5:4]};
  endfunction
  function automatic logic [7:0] up4(logic [3:0] c);
    return {c, c};
  endfunction

  always_comb begin
    case (depth_i)
      DEPTH_16I: rgb_o = {up5(field_i[4:0]), up5(field_i[9:5]),  up5(field_i[14:10])};
      DEPTH_565: rgb_o = {up5(field_i[4:0]), up6(field_i[10:5]), up5(field_i[15:11])};
      DEPTH_444: rgb_o = {up4(field_i[3:0]), up4(field_i[7:4]),  up4(field_i[11:8])};
      DEPTH_24:  rgb_o = {field_i[7:0], field_i[15:8], field_i[23:16]};
      default:   rgb_o = '0;
    endcase
  end
endmodule

// File: rtl/pix_palette_ram.sv
module pix_palette_ram #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read-before-write: same-edge write is not visible
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end

  assert_write_lands_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i) |-> (mem_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_unpack_pkg::*;
#(
  parameter int PAL_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              byte_be_i,
  input  logic              pix_be_i,
  input  logic              swap_rb_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  input  logic              pix_en_i,
  input  logic              pal_we_i,
  input  logic [PAL_AW-1:0] pal_waddr_i,
  input  logic [RGB_W-1:0]  pal_wdata_i,
  output logic [RGB_W-1:0]  pix_o,
  output logic              pix_valid_o
);
  depth_e           depth;
  logic             fire;
  logic [RGB_W-1:0] field, rgb_d, pal_rdata, rgb_q, sel;
  logic             valid_q, use_pal_q, swap_q;

  assign depth = depth_e'(mode_i);

  pix_word_slicer u_slicer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .depth_i      (depth),
    .byte_be_i    (byte_be_i),
    .pix_be_i     (pix_be_i),
    .word_i       (word_i),
    .word_valid_i (word_valid_i),
    .word_ready_o (word_ready_o),
    .pix_en_i     (pix_en_i),
    .fire_o       (fire),
    .field_o      (field)
  );

  pix_color_expand u_expand (
    .depth_i (depth),
    .field_i (field),
    .rgb_o   (rgb_d)
  );

  pix_palette_ram #(.AW(PAL_AW), .DW(RGB_W)) u_palette (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pal_we_i),
    .waddr_i (pal_waddr_i),
    .wdata_i (pal_wdata_i),
    .re_i    (fire && is_indexed(depth)),
    .raddr_i (field[PAL_AW-1:0]),
    .rdata_o (pal_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      use_pal_q <= 1'b0;
      swap_q    <= 1'b0;
      rgb_q     <= '0;
    end else begin
      valid_q <= fire;
      if (fire) begin
        use_pal_q <= is_indexed(depth);
        swap_q    <= swap_rb_i;
        rgb_q     <= rgb_d;
      end
    end
  end

  assign sel         = use_pal_q ? pal_rdata : rgb_q;
  assign pix_o       = swap_q ? {sel[7:0], sel[15:8], sel[23:16]} : sel;
  assign pix_valid_o = valid_q;

  assert_valid_needs_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> $past(pix_en_i));
  assert_hold_when_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> $stable(pix_o));
endmodule

// File: tb/pix_unpack_tb_top.sv
module pix_unpack_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  mode = '0;
  logic        byte_be = 0, pix_be = 0, swap_rb = 0;
  logic [31:0] word = '0;
  logic        word_valid = 0, pix_en = 0, pal_we = 0;
  logic [7:0]  pal_waddr = '0;
  logic [23:0] pal_wdata = '0;
  logic        word_ready, pix_valid;
  logic [23:0] pix;

  int checks = 0, errors = 0;

  logic [23:0] pal_m [256];
  bit          m_have = 0;
  int unsigned m_fields [$];
  logic [23:0] m_last = '0;

  always #2 clk = ~clk;

  pix_unpack dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .byte_be_i(byte_be),
    .pix_be_i(pix_be), .swap_rb_i(swap_rb), .word_i(word),
    .word_valid_i(word_valid), .word_ready_o(word_ready), .pix_en_i(pix_en),
    .pal_we_i(pal_we), .pal_waddr_i(pal_waddr), .pal_wdata_i(pal_wdata),
    .pix_o(pix), .pix_valid_o(pix_valid)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] e5(logic [31:0] c); return {c[4:0], c[4:2]}; endfunction
  function automatic logic [7:0] e6(logic [31:0] c); return {c[5:0], c[5:4]}; endfunction
  function automatic logic [7:0] e4(logic [31:0] c); return {c[3:0], c[3:0]}; endfunction

  function automatic logic [23:0] resolve(logic [31:0] f, int md, bit sw);
    logic [7:0] r, g, b;
    logic [23:0] x;
    case (md)
      4: begin r = e5(f);       g = e5(f >> 5);  b = e5(f >> 10); end
      5: begin r = f[7:0];      g = f[15:8];     b = f[23:16];    end
      6: begin r = e5(f);       g = e6(f >> 5);  b = e5(f >> 11); end
      7: begin r = e4(f);       g = e4(f >> 4);  b = e4(f >> 8);  end
      default: begin x = pal_m[f[7:0]]; r = x[23:16]; g = x[15:8]; b = x[7:0]; end
    endcase
    return sw ? {b, g, r} : {r, g, b};
  endfunction

  function automatic void split(logic [31:0] w, int md, bit bbe, bit pbe);
    int bpp, n, per, pos;
    logic [31:0] wr;
    wr = bbe ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    case (md)
      0: bpp = 1; 1: bpp = 2; 2: bpp = 4; 3: bpp = 8; 5: bpp = 32;
      default: bpp = 16;
    endcase
    n = 32 / bpp;
    for (int k = 0; k < n; k++) begin
      if (bpp < 8) begin
        per = 8 / bpp;
        pos = (k / per) * 8 + (pbe ? (per - 1 - k % per) : (k % per)) * bpp;
      end else pos = k * bpp;
      if (bpp == 32) m_fields.push_back(wr & 32'h00ff_ffff);
      else           m_fields.push_back((wr >> pos) & ((32'd1 << bpp) - 1));
    end
  endfunction

  task automatic step(string tag);
    logic        ev;
    logic [23:0] ep;
    @(posedge clk); #1;
    ev = 0; ep = m_last;
    if (m_have && pix_en) begin
      ev = 1;
      ep = resolve(m_fields.pop_front(), int'(mode), swap_rb);
      if (m_fields.size() == 0) m_have = 0;
    end else if (!m_have && word_valid) begin
      split(word, int'(mode), byte_be, pix_be);
      m_have = 1;
    end
    if (pal_we) pal_m[pal_waddr] = pal_wdata;
    chk({tag, " R4"}, "pix_valid_o", {31'd0, pix_valid}, {31'd0, ev});
    chk(tag, "pix_o", {8'd0, pix}, {8'd0, ep});
    chk("R2", "word_ready_o", {31'd0, word_ready}, {31'd0, !m_have});
    m_last = ep;
  endtask

  task automatic send_word(logic [31:0] w, string tag, int gap);
    word = w; word_valid = 1;
    do step(tag); while (!m_have);
    word_valid = 0;
    while (m_have) begin
      pix_en = 1; step(tag); pix_en = 0;
      repeat (gap) step(tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    string mtag [8];
    string tg;
    mtag = '{"R7", "R7", "R7", "R7", "R9", "R12", "R10", "R11"};
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "pix_valid_o", {31'd0, pix_valid}, 32'd0);
    chk("R1", "pix_o", {8'd0, pix}, 32'd0);
    chk("R1", "word_ready_o", {31'd0, word_ready}, 32'd1);
    rst_ni = 1;
    step("R1");

    for (int i = 0; i < 256; i++) begin
      pal_we = 1; pal_waddr = 8'(i);
      pal_wdata = {8'(i), 8'(i * 37 + 5), ~8'(i)};
      step("R8");
    end
    pal_we = 0;

    for (int md = 0; md < 8; md++) begin
      for (int c = 0; c < 4; c++) begin
        mode = 3'(md); byte_be = c[0]; pix_be = c[1]; swap_rb = (c == 1 || c == 2);
        tg = {mtag[md], " R3 R5 R13", (md < 3) ? " R6" : ""};
        send_word(32'h9e37_79b9 * (md * 4 + c + 1), tg, 1);
        send_word(32'h7f4a_7c15 ^ (32'(md) << (c * 8)), tg, 0);
      end
    end

    mode = 3'd4; byte_be = 0; swap_rb = 0;
    send_word(32'hffff_7fff, "R9", 0);
    send_word(32'h8421_0421, "R9", 2);
    mode = 3'd5;
    send_word(32'hab12_3456, "R12", 0);

    pix_en = 1;
    repeat (3) step("R3");
    pix_en = 0;

    mode = 3'd3; byte_be = 0; swap_rb = 0;
    word = 32'h3333_3333; word_valid = 1;
    do step("R8"); while (!m_have);
    word_valid = 0;
    pix_en = 1; pal_we = 1; pal_waddr = 8'h33; pal_wdata = 24'h12_3456;
    step("R8");
    pal_we = 0;
    while (m_have) step("R8");
    pix_en = 0;
    step("R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule